// File: doc/BRIEF.md
# Eight-Channel Match Timer with Shared Counters

The block holds eight timer channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word sets four things: which of five external tick enables advances the counter, whether a match clears the counter, whether matching stays armed after an event, and whether the channel borrows the counter of a lead channel. When a counter steps onto a channel's match value, the event sets that channel's status bit, provided the channel's enable bit is set. A single interrupt line stays high while any status bit is set.

Software reaches the block through a simple word-wide register bus. Read data is registered and appears on the cycle after the read strobe. The tick inputs are one-cycle enables that arrive already synchronous to `clk`; the dividers that produce them sit outside this block. Channels 9 and 11 can also freeze the value of their lead counter: reading their own counter with the capture bit set copies the lead counter into a snapshot register, which software can read afterwards.

Top module: `mc_match_timer`

## Requirements
- R1: After reset, every counter, match register, control register, the snapshot register, the status register and the enable register read as zero, and `irq_o` is low.
- R2: Channel 4+n (n = 0..7) is addressed as follows: counter at 0x40+4n, match at 0x80+4n, control at 0xC0+4n. The snapshot register is at 0x20, status at 0x14 and enable at 0x1C. Read data appears the cycle after `rd_en`, and unmapped reads return zero.
- R3: Control bits [2:0] pick the tick source: values 1 to 5 select `tick_i[0]` to `tick_i[4]`, and 0, 6 and 7 mean stopped. A running counter adds one on each cycle its selected tick is high.
- R4: A stopped counter keeps its value, and reads return that value.
- R5: Control registers of channels 4 to 7 keep bits [7:0]. Those of channels 8 to 11 keep bits [9:0]. In channels 8 to 11, bit 8 set forces the counter to stopped.
- R6: Channels 4, 8 and 10 always run their own counter. Any other channel with control bit 7 clear has its own counter halted and compares against a lead counter: counter 4 for channels 5 to 7, counter 8 for channel 9, counter 10 for channel 11.
- R7: An armed channel raises an event when its compared counter steps to a value equal to its match register. A write to the channel's match register or control register arms it.
- R8: With control bit 6 clear, a channel disarms after one event. With bit 6 set, it stays armed and raises an event each time the equality recurs.
- R9: With control bit 3 set, the step that would reach the match value instead loads zero into the counter being compared. When the channel shares a counter, that counter is the lead counter.
- R10: The enable register keeps bits [11:0]. An event sets status bit 4+n only when enable bit 4+n is set.
- R11: Writing a 1 to status bit 4+n clears it. `irq_o` is high while any of status bits [11:4] is set, and falls only after a write clears the last one.
- R12: Reading counter 9 (0x54) with its control bit 9 set copies counter 8 into the snapshot register. Reading counter 11 (0x5C) with its control bit 9 set copies counter 10. No other action changes the snapshot register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| tick_i | input | 5 | One-cycle tick enables for sources 1 to 5 |
| irq_o | output | 1 | Shared interrupt, high while any channel status bit is set |

## Verification
The assertions assume that each tick enable is a clean one-cycle pulse in the `clk` domain. They also assume that a counter is never written on the same edge as a tick that would advance it, and that reads and writes use word-aligned addresses and never share a cycle. The stimulus keeps within these limits in three ways: it drives ticks only through a pulse task that leaves a low cycle between pulses, it finishes every register write before it sends any tick, and it issues each bus access on its own cycle. All expected counts follow from the number of pulses sent after the last counter write.

// File: rtl/mc_match_timer.sv
module mc_match_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [4:0]    tick_i,
  output logic          irq_o
);
  localparam int NCH = 8;
  localparam int IW  = $clog2(NCH);
  localparam logic [7:0] A_SNAP = 8'h20;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_IEN  = 8'h1C;
  localparam logic [7:0] A_CAP9 = 8'h54;
  localparam logic [7:0] A_CAPB = 8'h5C;

  logic [CW-1:0]  cnt_q   [NCH];
  logic [CW-1:0]  match_q [NCH];
  logic [9:0]     ctrl_q  [NCH];
  logic [IW-1:0]  bsel    [NCH];
  logic [NCH-1:0] own, run, ev, clr, armed_q, stat_q;
  logic [11:0]    ien_q;
  logic [CW-1:0]  snap_q;

  wire          aligned = (addr[1:0] == 2'b00);
  wire [IW-1:0] idx     = addr[4:2];
  wire          a_cnt   = aligned && addr[7:5] == 3'b010;
  wire          a_match = aligned && addr[7:5] == 3'b100;
  wire          a_ctrl  = aligned && addr[7:5] == 3'b110;

  always_comb begin
    clr = '0;
    for (int k = 0; k < NCH; k++)
      if (ev[k] && ctrl_q[k][3]) clr[bsel[k]] = 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_ch
      localparam int  BASE = (k < 4) ? 0 : ((k < 6) ? 4 : 6);
      localparam bit  WIDE = (k >= 4);
      localparam bit  LEAD = (k == 0) || (k == 4) || (k == 6);
      logic [2:0] src;
      logic       tk;

      assign own[k]  = LEAD || ctrl_q[k][7];
      assign bsel[k] = own[k] ? IW'(k) : IW'(BASE);
      assign src     = (WIDE && ctrl_q[k][8]) ? 3'd0 : ctrl_q[k][2:0];

      always_comb begin
        case (src)
          3'd1:    tk = tick_i[0];
          3'd2:    tk = tick_i[1];
          3'd3:    tk = tick_i[2];
          3'd4:    tk = tick_i[3];
          3'd5:    tk = tick_i[4];
          default: tk = 1'b0;
        endcase
      end

      assign run[k] = own[k] && tk;
      assign ev[k]  = armed_q[k] && run[bsel[k]] &&
                      (cnt_q[bsel[k]] + CW'(1) == match_q[k]);

      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt_q[k] <= '0;
        else if (wr_en && a_cnt && idx == IW'(k))
          cnt_q[k] <= wdata;
        else if (run[k])
          cnt_q[k] <= clr[k] ? '0 : cnt_q[k] + CW'(1);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          match_q[k] <= '0;
          ctrl_q[k]  <= '0;
          armed_q[k] <= 1'b0;
        end else begin
          if (wr_en && a_match && idx == IW'(k))
            match_q[k] <= wdata;
          if (wr_en && a_ctrl && idx == IW'(k))
            ctrl_q[k] <= WIDE ? wdata[9:0] : {2'b00, wdata[7:0]};
          if (wr_en && (a_match || a_ctrl) && idx == IW'(k))
            armed_q[k] <= 1'b1;
          else if (ev[k] && !ctrl_q[k][6])
            armed_q[k] <= 1'b0;
        end
      end

      assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[k]) |-> $past(ien_q[k+4]));

      if (!LEAD) begin : g_follow
        assert_follow_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (!ctrl_q[k][7] && !(wr_en && a_cnt && idx == IW'(k))) |=> $stable(cnt_q[k]));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~((wr_en && addr == A_STAT) ? wdata[11:4] : '0))
              | (ev & ien_q[11:4]);
      if (wr_en && addr == A_IEN) ien_q <= wdata[11:0];
    end
  end

  assign irq_o = |stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      rdata  <= '0;
    end else begin
      if (rd_en && addr == A_CAP9 && ctrl_q[5][9]) snap_q <= cnt_q[4];
      if (rd_en && addr == A_CAPB && ctrl_q[7][9]) snap_q <= cnt_q[6];
      if (!rd_en)             rdata <= '0;
      else if (a_cnt)         rdata <= cnt_q[idx];
      else if (a_match)       rdata <= match_q[idx];
      else if (a_ctrl)        rdata <= CW'(ctrl_q[idx]);
      else if (addr == A_SNAP) rdata <= snap_q;
      else if (addr == A_STAT) rdata <= CW'({stat_q, 4'b0000});
      else if (addr == A_IEN)  rdata <= CW'(ien_q);
      else                     rdata <= '0;
    end
  end

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0][2:0] == 3'd0 && !(wr_en && addr == 8'h40)) |=> $stable(cnt_q[0]));

  assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_en && addr == A_STAT));

  assert_snap_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_q) |-> $past(rd_en && (addr == A_CAP9 || addr == A_CAPB)));

endmodule

// File: tb/mc_match_timer_tb_top.sv
module mc_match_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  tick = '0;
  logic [31:0] rdata;
  logic        irq;

  mc_match_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_i(tick), .irq_o(irq));

  always #10 clk = ~clk;

  logic [31:0] exp_q[$];
  string       req_q[$];
  logic [7:0]  adr_q[$];
  int vec = 0, bad = 0;
  logic look = 1'b0;
  logic [31:0] e_m;
  string r_m;
  logic [7:0] a_m;

  always @(posedge clk) look <= rd_en;

  always @(negedge clk) begin
    if (look) begin
      e_m = exp_q.pop_front();
      r_m = req_q.pop_front();
      a_m = adr_q.pop_front();
      vec++;
      if (rdata !== e_m) begin
        bad++;
        $display("FAIL %s read %h: got %h expected %h", r_m, a_m, rdata, e_m);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    exp_q.push_back(e); req_q.push_back(r); adr_q.push_back(a);
    rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = '0;
    end
  endtask

  task automatic chk_irq(input logic e, input string r);
    @(negedge clk);
    vec++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq: got %b expected %b", r, irq, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(8'h40, 0, "R1"); rd(8'h9C, 0, "R1"); rd(8'hDC, 0, "R1");
    rd(8'h20, 0, "R1"); rd(8'h14, 0, "R1"); rd(8'h1C, 0, "R1");
    // R2 map and round trip, R4 stopped counter holds
    wr(8'h84, 32'hDEADBEEF); rd(8'h84, 32'hDEADBEEF, "R2");
    wr(8'h48, 32'h1234);     rd(8'h48, 32'h1234, "R2");
    rd(8'h60, 0, "R2");
    pulse(5'h1F, 2);         rd(8'h48, 32'h1234, "R4");
    // R10 enable width
    wr(8'h1C, 32'hFFFFFFFF); rd(8'h1C, 32'hFFF, "R10");
    wr(8'h1C, 0);
    // R5 control widths
    wr(8'hC0, 32'hFFFFFFFF); rd(8'hC0, 32'hFF, "R5");
    wr(8'hD0, 32'hFFFFFFFF); rd(8'hD0, 32'h3FF, "R5");
    wr(8'hC0, 0); wr(8'hD0, 0);
    // R3 source selection
    wr(8'hC0, 32'h81); wr(8'h40, 0);
    pulse(5'h01, 5); rd(8'h40, 5, "R3");
    pulse(5'h02, 3); rd(8'h40, 5, "R3");
    wr(8'hC0, 32'h04); pulse(5'h08, 2); rd(8'h40, 7, "R3");
    wr(8'hC0, 32'h06); pulse(5'h1F, 2); rd(8'h40, 7, "R4");
    wr(8'hC0, 32'h07); pulse(5'h1F, 1); rd(8'h40, 7, "R4");
    wr(8'hC0, 32'h05); pulse(5'h10, 1); rd(8'h40, 8, "R3");
    // R5 forced stop in wide control
    wr(8'hD0, 32'h181); wr(8'h50, 0);
    pulse(5'h01, 3); rd(8'h50, 0, "R5");
    wr(8'hD0, 32'h081); pulse(5'h01, 3); rd(8'h50, 3, "R5");
    // R6 sharing halts own counter
    wr(8'hC4, 32'h01); pulse(5'h01, 2); rd(8'h44, 0, "R6");
    wr(8'hC4, 32'h81); pulse(5'h01, 2); rd(8'h44, 2, "R6");
    // R7 match on shared counter, R11 clear
    wr(8'h1C, 32'h020); wr(8'hC0, 32'h01); wr(8'h40, 0);
    wr(8'hC4, 32'h01); wr(8'h84, 3);
    pulse(5'h01, 2); rd(8'h14, 0, "R7"); chk_irq(1'b0, "R7");
    pulse(5'h01, 1); rd(8'h14, 32'h20, "R7"); chk_irq(1'b1, "R11");
    wr(8'h14, 32'h20); rd(8'h14, 0, "R11"); chk_irq(1'b0, "R11");
    // R8 one-shot stays disarmed
    wr(8'h40, 0); pulse(5'h01, 3); rd(8'h14, 0, "R8");
    // R9 periodic with clear of shared counter
    wr(8'hC4, 32'h49); wr(8'h40, 0);
    pulse(5'h01, 3); rd(8'h14, 32'h20, "R9"); rd(8'h40, 0, "R9");
    wr(8'h14, 32'h20);
    pulse(5'h01, 3); rd(8'h14, 32'h20, "R8"); rd(8'h40, 0, "R9");
    wr(8'h14, 32'h20);
    // R10 gating
    wr(8'h1C, 0); pulse(5'h01, 3); rd(8'h14, 0, "R10"); chk_irq(1'b0, "R10");
    // R11 partial clear
    wr(8'h1C, 32'h030); wr(8'h80, 3); wr(8'h40, 0);
    pulse(5'h01, 3); rd(8'h14, 32'h30, "R7"); chk_irq(1'b1, "R11");
    wr(8'h14, 32'h10); rd(8'h14, 32'h20, "R11"); chk_irq(1'b1, "R11");
    wr(8'h14, 32'h20); chk_irq(1'b0, "R11"); rd(8'h14, 0, "R11");
    // R12 snapshot
    wr(8'h50, 32'h55); wr(8'hD4, 32'h200);
    rd(8'h20, 0, "R12"); rd(8'h54, 0, "R12"); rd(8'h20, 32'h55, "R12");
    wr(8'h58, 32'h77); rd(8'h5C, 0, "R12"); rd(8'h20, 32'h55, "R12");
    wr(8'hDC, 32'h200); rd(8'h5C, 0, "R12"); rd(8'h20, 32'h77, "R12");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule